// File: doc/BRIEF.md
# Random Generator Control and Status Unit

This block is the software-facing shell of a hardware random number generator. It sits on a simple 32-bit register bus (write strobe, read strobe, byte address, write data, combinational read data). Through it software enables generation, sets up the entropy configuration and the clock-divider exponent, and reads random words. It also watches two injected fault inputs, a seed fault and a clock fault, and reports them through current-state and sticky interrupt flags. A pseudo-random stand-in source produces the words, so that the register behaviour can be built and checked without any analog circuitry.

Configuration is guarded by a conditional-reset handshake. The configuration fields are only taken from a control write that also raises the conditional-reset bit. That bit reads back as 1 until the internal reset has run out after software lowers it again. A seed fault stops generation. A short fault recovers by itself and leaves only the interrupt flag for software to clear. A long fault keeps the current seed-error flag set until a conditional reset completes. While that flag is set, a data read returns zero. A lock bit freezes all configuration until the next hardware reset.

Top module: `rng_ctrl_unit`

## Requirements
- R1: Registers sit at byte offsets control 0x00, status 0x04, data 0x08, noise-source control 0x0C and health-test control 0x10. Any other address reads 0 and ignores writes. After reset, control, status, noise and health all read 0. Control bit 2 (enable) takes the written value on every control write.
- R2: Status bits are ready at bit 0, current clock error at bit 1, current seed error at bit 2, clock-error interrupt at bit 5 and seed-error interrupt at bit 6. A status write with 0 in bit 5 or bit 6 clears that interrupt flag. Writing 1 there has no effect. Bits 0 to 2 are read-only.
- R3: The noise-source register keeps bits 17:0 of a write and reads 0 above them. The health-test register keeps all 32 bits.
- R4: The control configuration bits (bit 5 clock-check disable, bits 25:8 including the divider exponent at 19:16) change only in a control write that also carries bit 30 = 1. In any other control write they keep their value.
- R5: Control bit 30 reads 1 from the write that sets it until RST_CYCLES (default 3) clock cycles after the control write that clears it. At that completion the seed-error interrupt clears, and the current seed error clears if the fault input is low.
- R6: Control bit 31 (lock), once written 1, stays 1 until hardware reset. While it is set, the configuration bits, the noise register and the health register ignore writes. The conditional reset handshake still runs.
- R7: A cycle with the seed-fault input high sets both the current seed-error flag and the seed-error interrupt flag at the next clock edge. Generation pauses while the current flag is set.
- R8: A seed fault lasting fewer than AUTO_WIN (default 4) consecutive cycles clears the current seed-error flag one cycle after the fault drops and leaves the interrupt flag set. A fault lasting AUTO_WIN cycles or more keeps the current flag set until a conditional reset completes.
- R9: A data-register read while the current seed-error flag is set returns 0.
- R10: Ready rises GEN_CYCLES << div clock edges (GEN_CYCLES default 4, div = control bits 19:16) after generation becomes eligible (enabled, no current seed error, no conditional reset in progress). A data read clears ready and restarts the count. Ready is low while enable is clear or a conditional reset runs.
- R11: Each rise of ready advances the source once. The k-th word after reset is the xorshift32 step (x^=x<<13, x^=x>>17, x^=x<<5) applied k times to SEED (default 0x12345678). A word is never zero.
- R12: A clock fault while control bit 5 is 0 sets the current clock-error flag and the clock-error interrupt at the next edge. The current flag follows the fault. The interrupt is sticky. With bit 5 = 1 neither flag sets.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects on the data register) |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| seed_fault_i | input | 1 | Injected seed (noise source) fault |
| clk_fault_i | input | 1 | Injected clock fault |

## Verification
The assertions check on every cycle the relations that hold from one edge to the next. Fault inputs must set their flags. The seed interrupt may fall only through a status write or a completed conditional reset. Ready must stay low without enable and drop after a read. Zero words are returned under a seed error, and the lock bit must never fall. Only the bench's scenarios can show the durations that depend on the configuration. These are the ready latency for each divider exponent, the length of the reset handshake and the auto-recovery boundary around AUTO_WIN. The bench also shows the word sequence of the source and that configuration writes are ignored without the reset bit or under lock.

// File: rtl/rng_pkg.sv
package rng_pkg;
   localparam int WORD_W  = 32;
   localparam int NOISE_W = 18;
   localparam int DIV_W   = 4;

   localparam logic [7:0] OFF_CTRL   = 8'h00;
   localparam logic [7:0] OFF_STAT   = 8'h04;
   localparam logic [7:0] OFF_DATA   = 8'h08;
   localparam logic [7:0] OFF_NOISE  = 8'h0C;
   localparam logic [7:0] OFF_HEALTH = 8'h10;

   // control register bit positions
   localparam int CB_EN     = 2;
   localparam int CB_CLKOFF = 5;
   localparam int CB_DIV    = 16;
   localparam int CB_CRST   = 30;
   localparam int CB_LOCK   = 31;
   localparam logic [WORD_W-1:0] CFG_MASK = 32'h03FF_FF20;

   // status register bit positions
   localparam int SB_RDY     = 0;
   localparam int SB_CLKNOW  = 1;
   localparam int SB_SEEDNOW = 2;
   localparam int SB_CLKIRQ  = 5;
   localparam int SB_SEEDIRQ = 6;
endpackage

// File: rtl/rng_word_src.sv
module rng_word_src #(
   parameter logic [31:0] SEED = 32'h1234_5678,
   parameter int          KIND = 0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        step,
   output logic [31:0] word
);
   localparam logic [31:0] TAPS = 32'h8020_0003;
   logic [31:0] nxt;

   generate
      if (KIND == 0) begin : g_xorshift
         logic [31:0] s1, s2;
         assign s1  = word ^ (word << 13);
         assign s2  = s1 ^ (s1 >> 17);
         assign nxt = s2 ^ (s2 << 5);
      end else begin : g_galois
         assign nxt = word[0] ? ((word >> 1) ^ TAPS) : (word >> 1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    word <= SEED;
      else if (step) word <= nxt;
   end
endmodule

// File: rtl/rng_cond_reset.sv
module rng_cond_reset #(
   parameter int RST_CYCLES = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_set,
   input  logic req_clr,
   output logic busy,
   output logic done
);
   localparam int CW = $clog2(RST_CYCLES + 1);
   logic          hold_q;
   logic [CW-1:0] cnt_q;

   assign busy = hold_q || (cnt_q != '0);
   assign done = !req_set && !hold_q && (cnt_q == CW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= 1'b0;
         cnt_q  <= '0;
      end else if (req_set) begin
         hold_q <= 1'b1;
         cnt_q  <= CW'(RST_CYCLES);
      end else begin
         if (req_clr) hold_q <= 1'b0;
         if (!hold_q && cnt_q != '0) cnt_q <= cnt_q - CW'(1);
      end
   end
endmodule

// File: rtl/rng_seed_monitor.sv
module rng_seed_monitor #(
   parameter int AUTO_WIN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fault,
   input  logic crst_done,
   input  logic irq_clr,
   output logic secs,
   output logic seis
);
   localparam int CW = $clog2(AUTO_WIN + 1);
   logic [CW-1:0] run_q;
   logic          hard_q, hard_nx;

   always_comb begin
      hard_nx = hard_q;
      if (fault && run_q == CW'(AUTO_WIN - 1)) hard_nx = 1'b1;
      else if (crst_done && !fault)            hard_nx = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= '0;
         hard_q <= 1'b0;
         secs   <= 1'b0;
         seis   <= 1'b0;
      end else begin
         if (!fault)                       run_q <= '0;
         else if (run_q != CW'(AUTO_WIN))  run_q <= run_q + CW'(1);
         hard_q <= hard_nx;
         secs   <= fault || hard_nx;
         if (fault)                        seis <= 1'b1;
         else if (crst_done || irq_clr)    seis <= 1'b0;
      end
   end
endmodule

// File: rtl/rng_ready_timer.sv
module rng_ready_timer #(
   parameter int GEN_CYCLES = 4,
   parameter int DIV_W      = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             halt,
   input  logic             stall,
   input  logic             pop,
   input  logic [DIV_W-1:0] div,
   output logic             ready,
   output logic             capture
);
   localparam int CNT_W = $clog2(GEN_CYCLES + 1) + (1 << DIV_W);
   logic [CNT_W-1:0] t_q, lim_m1;

   assign lim_m1  = (CNT_W'(GEN_CYCLES) << div) - CNT_W'(1);
   assign capture = !halt && !pop && !ready && !stall && (t_q == lim_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ready <= 1'b0;
         t_q   <= '0;
      end else if (halt || pop) begin
         ready <= 1'b0;
         t_q   <= '0;
      end else if (ready || stall) begin
         t_q   <= '0;
      end else if (capture) begin
         ready <= 1'b1;
         t_q   <= '0;
      end else begin
         t_q   <= t_q + CNT_W'(1);
      end
   end
endmodule

// File: rtl/rng_ctrl_unit.sv
module rng_ctrl_unit #(
   parameter int          ADDR_W     = 5,
   parameter int          GEN_CYCLES = 4,
   parameter int          RST_CYCLES = 3,
   parameter int          AUTO_WIN   = 4,
   parameter logic [31:0] SEED       = 32'h1234_5678,
   parameter int          SRC_KIND   = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              seed_fault_i,
   input  logic              clk_fault_i
);
   import rng_pkg::*;

   generate
      if (ADDR_W < 5 || ADDR_W > 8) begin : g_bad_addr
         $error("ADDR_W must lie in 5..8");
      end
      if (GEN_CYCLES < 1 || RST_CYCLES < 1 || AUTO_WIN < 1) begin : g_bad_cnt
         $error("cycle counts must be at least 1");
      end
      if (SEED == 32'h0) begin : g_bad_seed
         $error("SEED must be nonzero");
      end
      if (SRC_KIND < 0 || SRC_KIND > 1) begin : g_bad_kind
         $error("SRC_KIND must be 0 or 1");
      end
   endgenerate

   localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFF_CTRL);
   localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(OFF_STAT);
   localparam logic [ADDR_W-1:0] A_DATA   = ADDR_W'(OFF_DATA);
   localparam logic [ADDR_W-1:0] A_NOISE  = ADDR_W'(OFF_NOISE);
   localparam logic [ADDR_W-1:0] A_HEALTH = ADDR_W'(OFF_HEALTH);

   logic ctrl_wr, stat_wr, noise_wr, health_wr, data_pop;
   assign ctrl_wr   = bus_wr && bus_addr == A_CTRL;
   assign stat_wr   = bus_wr && bus_addr == A_STAT;
   assign noise_wr  = bus_wr && bus_addr == A_NOISE;
   assign health_wr = bus_wr && bus_addr == A_HEALTH;
   assign data_pop  = bus_rd && bus_addr == A_DATA;

   logic               en_q, lock_q, cecs_q, ceis_q;
   logic [WORD_W-1:0]  cfg_q, health_q;
   logic [NOISE_W-1:0] noise_q;
   logic               busy, crst_done, secs, seis, drdy, capture;
   logic [WORD_W-1:0]  word;
   logic               clk_err_now;

   assign clk_err_now = clk_fault_i && !cfg_q[CB_CLKOFF];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q     <= 1'b0;
         lock_q   <= 1'b0;
         cfg_q    <= '0;
         noise_q  <= '0;
         health_q <= '0;
         cecs_q   <= 1'b0;
         ceis_q   <= 1'b0;
      end else begin
         if (ctrl_wr) begin
            en_q   <= bus_wdata[CB_EN];
            lock_q <= lock_q || bus_wdata[CB_LOCK];
            if (bus_wdata[CB_CRST] && !lock_q) cfg_q <= bus_wdata & CFG_MASK;
         end
         if (noise_wr && !lock_q)  noise_q  <= bus_wdata[NOISE_W-1:0];
         if (health_wr && !lock_q) health_q <= bus_wdata;
         cecs_q <= clk_err_now;
         if (clk_err_now)                         ceis_q <= 1'b1;
         else if (stat_wr && !bus_wdata[SB_CLKIRQ]) ceis_q <= 1'b0;
      end
   end

   rng_cond_reset #(.RST_CYCLES(RST_CYCLES)) u_crst (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_set (ctrl_wr && bus_wdata[CB_CRST]),
      .req_clr (ctrl_wr && !bus_wdata[CB_CRST]),
      .busy    (busy),
      .done    (crst_done)
   );

   rng_seed_monitor #(.AUTO_WIN(AUTO_WIN)) u_seed (
      .clk       (clk),
      .rst_n     (rst_n),
      .fault     (seed_fault_i),
      .crst_done (crst_done),
      .irq_clr   (stat_wr && !bus_wdata[SB_SEEDIRQ]),
      .secs      (secs),
      .seis      (seis)
   );

   rng_ready_timer #(.GEN_CYCLES(GEN_CYCLES), .DIV_W(DIV_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .halt    (!en_q || busy),
      .stall   (secs),
      .pop     (data_pop),
      .div     (cfg_q[CB_DIV +: DIV_W]),
      .ready   (drdy),
      .capture (capture)
   );

   rng_word_src #(.SEED(SEED), .KIND(SRC_KIND)) u_src (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (capture),
      .word  (word)
   );

   logic [WORD_W-1:0] ctrl_view, stat_view;
   always_comb begin
      ctrl_view          = cfg_q;
      ctrl_view[CB_EN]   = en_q;
      ctrl_view[CB_CRST] = busy;
      ctrl_view[CB_LOCK] = lock_q;
      stat_view             = '0;
      stat_view[SB_RDY]     = drdy;
      stat_view[SB_CLKNOW]  = cecs_q;
      stat_view[SB_SEEDNOW] = secs;
      stat_view[SB_CLKIRQ]  = ceis_q;
      stat_view[SB_SEEDIRQ] = seis;
   end

   always_comb begin
      case (bus_addr)
         A_CTRL:   bus_rdata = ctrl_view;
         A_STAT:   bus_rdata = stat_view;
         A_DATA:   bus_rdata = secs ? '0 : word;
         A_NOISE:  bus_rdata = {{(WORD_W-NOISE_W){1'b0}}, noise_q};
         A_HEALTH: bus_rdata = health_q;
         default:  bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/rng_ctrl_chk.sv
module rng_ctrl_chk #(
   parameter int ADDR_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              wd_crst,
   input logic              wd_seedirq,
   input logic [31:0]       bus_rdata,
   input logic              seed_fault_i,
   input logic              clk_fault_i,
   input logic              en,
   input logic              lock,
   input logic              busy,
   input logic              secs,
   input logic              seis,
   input logic              drdy,
   input logic              cecs,
   input logic              ceis,
   input logic              clk_off
);
   import rng_pkg::*;
   logic at_ctrl, at_stat, at_data, at_noise;
   assign at_ctrl  = bus_addr == ADDR_W'(OFF_CTRL);
   assign at_stat  = bus_addr == ADDR_W'(OFF_STAT);
   assign at_data  = bus_addr == ADDR_W'(OFF_DATA);
   assign at_noise = bus_addr == ADDR_W'(OFF_NOISE);

   assert_fault_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
      seed_fault_i |=> (secs && seis));
   assert_zero_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (at_data && secs) |-> (bus_rdata == 32'h0));
   assert_ready_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !drdy);
   assert_pop_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && at_data && drdy) |=> !drdy);
   assert_crst_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && at_ctrl && wd_crst) |=> busy);
   assert_seedirq_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(seis) |-> ($past(bus_wr && at_stat && !wd_seedirq) || $fell(busy)));
   assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      lock |=> lock);
   assert_noise_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
      at_noise |-> (bus_rdata[31:18] == 14'h0));
   assert_clk_flags_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_fault_i && !clk_off) |=> (cecs && ceis));
endmodule

bind rng_ctrl_unit rng_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_wr       (bus_wr),
   .bus_rd       (bus_rd),
   .bus_addr     (bus_addr),
   .wd_crst      (bus_wdata[30]),
   .wd_seedirq   (bus_wdata[6]),
   .bus_rdata    (bus_rdata),
   .seed_fault_i (seed_fault_i),
   .clk_fault_i  (clk_fault_i),
   .en           (en_q),
   .lock         (lock_q),
   .busy         (busy),
   .secs         (secs),
   .seis         (seis),
   .drdy         (drdy),
   .cecs         (cecs_q),
   .ceis         (ceis_q),
   .clk_off      (cfg_q[5])
);

// File: tb/tb_rng_ctrl_unit.sv
module tb_rng_ctrl_unit;
   localparam int CLK_PERIOD = 10;
   localparam int GEN = 4;
   localparam int RST = 3;
   localparam int AUTO = 4;
   localparam logic [31:0] SEED = 32'h1234_5678;
   localparam logic [4:0] A_CTRL = 5'h00, A_STAT = 5'h04, A_DATA = 5'h08,
                          A_NOISE = 5'h0C, A_HEALTH = 5'h10;
   localparam logic [31:0] CRST = 32'h4000_0000, LOCK = 32'h8000_0000, EN = 32'h4;

   logic clk = 1'b0, rst_n = 1'b0;
   logic bus_wr = 1'b0, bus_rd = 1'b0;
   logic [4:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic seed_fault_i = 1'b0, clk_fault_i = 1'b0;
   int vecs = 0, errs = 0;

   rng_ctrl_unit dut (.*);

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [31:0] xs(input logic [31:0] x);
      logic [31:0] y;
      y = x ^ (x << 13);
      y = y ^ (y >> 17);
      return y ^ (y << 5);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vecs++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic peek(input logic [4:0] a, output logic [31:0] v);
      bus_rd = 1'b0; bus_addr = a;
      #1 v = bus_rdata;
   endtask

   task automatic pop(output logic [31:0] v);
      bus_addr = A_DATA; bus_rd = 1'b1;
      #1 v = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   // counts clock edges until the chosen bit reaches the wanted value
   task automatic wait_bit(input logic [4:0] a, input int b, input logic want, output int n);
      logic [31:0] v;
      n = 0;
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         n++;
         peek(a, v);
         if (v[b] == want) return;
      end
      n = 9999;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errs++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end

   initial begin
      logic [31:0] v, prev, w0;
      int n;
      do_reset();
      // R1 reset state and unmapped address
      peek(A_CTRL, v);   chk("R1 ctrl reset", v, 32'h0);
      peek(A_STAT, v);   chk("R1 stat reset", v, 32'h0);
      peek(A_NOISE, v);  chk("R1 noise reset", v, 32'h0);
      peek(A_HEALTH, v); chk("R1 health reset", v, 32'h0);
      wr(5'h14, 32'hFFFF_FFFF);
      peek(5'h14, v);    chk("R1 unmapped", v, 32'h0);

      // R10 / R11 enable, first word and a chain of words
      wr(A_CTRL, EN);
      peek(A_CTRL, v);   chk("R1 enable bit", v, EN);
      wait_bit(A_STAT, 0, 1'b1, n); chk("R10 first ready latency", n, GEN);
      pop(v);            chk("R11 first word", v, xs(SEED));
      prev = v;
      peek(A_STAT, v);   chk("R10 read clears ready", v & 32'h1, 32'h0);
      for (int k = 0; k < 5; k++) begin
         wait_bit(A_STAT, 0, 1'b1, n); chk("R10 ready latency", n, GEN);
         pop(v); chk("R11 word chain", v, xs(prev)); prev = v;
      end

      // R4 R5 R10 divider sweep through the reset handshake
      for (int div = 0; div < 4; div++) begin
         wr(A_CTRL, CRST | (32'(div) << 16) | EN);
         peek(A_CTRL, v); chk("R5 reset bit held", v, CRST | (32'(div) << 16) | EN);
         wr(A_CTRL, (32'(div) << 16) | EN);
         wait_bit(A_CTRL, 30, 1'b0, n); chk("R5 reset duration", n, RST);
         peek(A_CTRL, v); chk("R4 divider taken", v, (32'(div) << 16) | EN);
         wait_bit(A_STAT, 0, 1'b1, n); chk("R10 divided latency", n, GEN << div);
         pop(v); chk("R11 word after divider", v, xs(prev)); prev = v;
      end
      wr(A_CTRL, CRST | EN); wr(A_CTRL, EN);
      wait_bit(A_CTRL, 30, 1'b0, n);

      // R4 config ignored without reset bit, taken with it
      wr(A_CTRL, 32'h03FF_FF24);
      peek(A_CTRL, v); chk("R4 config ignored", v, EN);
      wr(A_CTRL, CRST | 32'h02A5_5A24);
      peek(A_CTRL, v); chk("R4 config with reset", v, 32'h42A5_5A24);
      wr(A_CTRL, 32'h0000_0004);
      wait_bit(A_CTRL, 30, 1'b0, n);
      peek(A_CTRL, v); chk("R4 config kept on release", v, 32'h02A5_5A24);

      // R12 clock check disabled, then enabled
      clk_fault_i = 1'b1; @(negedge clk);
      peek(A_STAT, v); chk("R12 disabled check", v & 32'h22, 32'h0);
      clk_fault_i = 1'b0;
      wr(A_CTRL, CRST | EN); wr(A_CTRL, EN);
      wait_bit(A_CTRL, 30, 1'b0, n);
      clk_fault_i = 1'b1; @(negedge clk);
      peek(A_STAT, v); chk("R12 clock flags set", v & 32'h22, 32'h22);
      clk_fault_i = 1'b0; @(negedge clk);
      peek(A_STAT, v); chk("R12 current clears, irq sticky", v & 32'h22, 32'h20);
      wr(A_STAT, 32'h0000_0067);
      peek(A_STAT, v); chk("R2 write one no effect", v & 32'h20, 32'h20);
      wr(A_STAT, 32'h0);
      peek(A_STAT, v); chk("R2 write zero clears", v & 32'h20, 32'h0);

      // R11 resynchronised chain
      wait_bit(A_STAT, 0, 1'b1, n);
      pop(w0); chk("R11 word nonzero", 32'(w0 != 0), 32'h1);
      wait_bit(A_STAT, 0, 1'b1, n);
      pop(v);  chk("R11 chain after resync", v, xs(w0));

      // R3 noise and health widths
      wr(A_NOISE, 32'hFFFF_FFFF);
      peek(A_NOISE, v);  chk("R3 noise width", v, 32'h0003_FFFF);
      wr(A_HEALTH, 32'hA5C3_9617);
      peek(A_HEALTH, v); chk("R3 health", v, 32'hA5C3_9617);

      // R7 R8 R9 R5 seed-fault duration sweep
      for (int d = 1; d <= 6; d++) begin
         seed_fault_i = 1'b1;
         @(negedge clk);
         peek(A_STAT, v); chk("R7 seed flags set", v & 32'h44, 32'h44);
         repeat (d - 1) @(negedge clk);
         seed_fault_i = 1'b0;
         @(negedge clk);
         peek(A_STAT, v);
         chk("R8 recovery kind", v & 32'h44, (d >= AUTO) ? 32'h44 : 32'h40);
         if (d < AUTO) begin
            wr(A_STAT, 32'h0);
            peek(A_STAT, v); chk("R8 irq cleared after auto", v & 32'h44, 32'h0);
         end else begin
            peek(A_DATA, v); chk("R9 data zero", v, 32'h0);
            repeat (5) @(negedge clk);
            peek(A_STAT, v); chk("R8 seed error held", v & 32'h4, 32'h4);
            pop(v); chk("R9 popped zero", v, 32'h0);
            wr(A_CTRL, CRST | EN); wr(A_CTRL, EN);
            wait_bit(A_CTRL, 30, 1'b0, n); chk("R5 reset duration", n, RST);
            peek(A_STAT, v); chk("R5 flags cleared", v & 32'h44, 32'h0);
            wait_bit(A_STAT, 0, 1'b1, n); chk("R10 ready after recovery", n, GEN);
         end
      end

      // R10 disable holds ready low
      wr(A_CTRL, 32'h0);
      @(negedge clk);
      peek(A_STAT, v); chk("R10 ready dropped", v & 32'h1, 32'h0);
      repeat (40) @(negedge clk);
      peek(A_STAT, v); chk("R10 ready stays low", v & 32'h1, 32'h0);

      // R6 lock
      wr(A_CTRL, LOCK | EN);
      peek(A_CTRL, v); chk("R6 lock set", v, LOCK | EN);
      wr(A_CTRL, LOCK | CRST | 32'h02A5_5A24);
      peek(A_CTRL, v); chk("R6 config frozen, reset runs", v, LOCK | CRST | EN);
      wr(A_CTRL, EN);
      wait_bit(A_CTRL, 30, 1'b0, n); chk("R6 handshake under lock", n, RST);
      peek(A_CTRL, v); chk("R6 lock sticky", v, LOCK | EN);
      wr(A_NOISE, 32'h155);
      peek(A_NOISE, v);  chk("R6 noise frozen", v, 32'h0003_FFFF);
      wr(A_HEALTH, 32'h1);
      peek(A_HEALTH, v); chk("R6 health frozen", v, 32'hA5C3_9617);
      do_reset();
      peek(A_CTRL, v); chk("R6 lock cleared by reset", v, 32'h0);

      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end
endmodule